// File: doc/BRIEF.md
# Windowed Horizontal-Sync Line Counter

This block counts the horizontal sync pulses that arrive during one video frame and reports the total, divided by four, through an 8-bit read-only status value. A pulse is counted only if its rising edge comes while the acceptance window from the horizontal PLL is open. Pulses outside the window are treated as noise and ignored. The block counts edges, not cycles, so a pulse that stays high for many clock cycles adds one to the count.

On each rising edge of vertical sync, the running count moves into a holding register and the counter starts again from zero. Between vertical syncs the holding register does not change. The host can therefore read it at any moment, whatever the video timing, and never sees a half-updated count. A read returns the held value only when the read strobe and the address match are both high. In every other cycle the read data is zero. If vertical sync never arrives, the running counter stops at its maximum value instead of wrapping around.

Top module: `hsync_line_counter`

## Requirements
- R1: After a synchronous active-high reset, the held count is 0, so a read returns 0.
- R2: Each rising edge of `hsync_i` seen while `win_ok_i` is 1 adds one to the running count. An hsync pulse that stays high for several cycles is counted once.
- R3: A rising edge of `hsync_i` seen while `win_ok_i` is 0 does not change the count.
- R4: On a rising edge of `vsync_i`, bits [9:2] of the 10-bit running count become the readable value, which is the count divided by four and rounded down. The running count then restarts at 0.
- R5: If a qualified hsync rising edge comes in the same cycle as the vsync rising edge, the latched value includes that pulse, and the next frame starts at 0.
- R6: The readable value changes only on a vsync rising edge. Hsync activity between vsync edges leaves it unchanged.
- R7: The running count saturates at 1023, which reads as 255, and never wraps.
- R8: `rd_data_o` equals the held value when `rd_en_i` and `rd_sel_i` are both 1, and is 0 in every other case.
- R9: A vsync that stays high for several cycles latches once, at its rising edge. Hsync pulses counted while vsync stays high belong to the new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_i | input | 1 | Horizontal sync pulse, active high |
| win_ok_i | input | 1 | PLL acceptance window open |
| vsync_i | input | 1 | Vertical sync pulse, active high |
| rd_en_i | input | 1 | Register read strobe |
| rd_sel_i | input | 1 | Register address match |
| rd_data_o | output | 8 | Read data: held count / 4, or 0 when not selected |

## Verification
Long hsync pulses are tried against single-cycle ones to separate edge counting from level counting. Pulses with the window closed are tried against pulses with it open to show that the window gate works. Counts of 7 and 8 pulses show that the divide-by-four rounds down. Three more cases each isolate one behaviour:
- a vsync edge in the same cycle as an hsync edge, which shows the latch-before-clear order;
- a vsync held high for many cycles, which shows single latching;
- a frame of 1100 pulses, which shows saturation.

Random hsync, window, vsync and read-strobe traffic is then compared against a reference model to catch interactions between these rules.

// File: rtl/hsl_pkg.sv
package hsl_pkg;

    localparam int unsigned HSL_CNT_W = 10;
    localparam int unsigned HSL_RPT_W = 8;

    typedef enum logic [1:0] {
        CNT_HOLD    = 2'd0,
        CNT_STEP    = 2'd1,
        CNT_RESTART = 2'd2
    } cnt_op_t;

    typedef struct packed {
        logic hs_rise;
        logic vs_rise;
    } sync_edges_t;

endpackage

// File: rtl/hsl_rise_det.sv
module hsl_rise_det #(
    parameter int unsigned LANES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] sig_i,
    output logic [LANES-1:0] rise_o
);
    logic [LANES-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= sig_i;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign rise_o[g] = sig_i[g] & ~prev_q[g];
    end

    // R9: an input that stays high for two samples gives no new edge
    p_level_no_edge_r9: assert property (@(posedge clk) disable iff (rst)
        (sig_i == $past(sig_i)) |-> (rise_o == '0));
endmodule

// File: rtl/hsl_run_counter.sv
module hsl_run_counter
    import hsl_pkg::*;
#(
    parameter int unsigned CNT_W = HSL_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_op_t          op_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] snap_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] bumped;

    assign bumped = (inc_i && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;
    assign snap_o = bumped;
    assign cnt_o  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            unique case (op_i)
                CNT_STEP:    cnt_q <= bumped;
                CNT_RESTART: cnt_q <= '0;
                default:     cnt_q <= cnt_q;
            endcase
        end
    end

    // R7: full counter stays full
    p_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && op_i != CNT_RESTART) |=> (cnt_q == CNT_MAX));

    // R2: a step below full grows the count by exactly one
    p_step_one_r2: assert property (@(posedge clk) disable iff (rst)
        (op_i == CNT_STEP && inc_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/hsl_hold_reg.sv
module hsl_hold_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst)        hold_q <= '0;
        else if (cap_i) hold_q <= d_i;
    end

    assign q_o = hold_q;

    // R6: no capture, no change
    p_hold_stable_r6: assert property (@(posedge clk) disable iff (rst)
        !cap_i |=> $stable(hold_q));
endmodule

// File: rtl/hsync_line_counter.sv
module hsync_line_counter
    import hsl_pkg::*;
#(
    parameter int unsigned CNT_W = HSL_CNT_W,
    parameter int unsigned RPT_W = HSL_RPT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hsync_i,
    input  logic             win_ok_i,
    input  logic             vsync_i,
    input  logic             rd_en_i,
    input  logic             rd_sel_i,
    output logic [RPT_W-1:0] rd_data_o
);
    localparam int unsigned DROP = CNT_W - RPT_W;

    logic [1:0]       rises;
    sync_edges_t      edges;
    logic             qual;
    cnt_op_t          op;
    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] snap;
    logic [RPT_W-1:0] held;

    hsl_rise_det #(.LANES(2)) u_rise (
        .clk   (clk),
        .rst   (rst),
        .sig_i ({hsync_i, vsync_i}),
        .rise_o(rises)
    );

    assign edges = sync_edges_t'(rises);
    assign qual  = edges.hs_rise & win_ok_i;

    always_comb begin
        if (edges.vs_rise) op = CNT_RESTART;
        else if (qual)     op = CNT_STEP;
        else               op = CNT_HOLD;
    end

    hsl_run_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .op_i  (op),
        .inc_i (qual),
        .cnt_o (run_cnt),
        .snap_o(snap)
    );

    hsl_hold_reg #(.W(RPT_W)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .cap_i(edges.vs_rise),
        .d_i  (snap[CNT_W-1:DROP]),
        .q_o  (held)
    );

    assign rd_data_o = (rd_en_i && rd_sel_i) ? held : '0;

    // R8: no selected read, no data
    p_rd_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !(rd_en_i && rd_sel_i) |-> (rd_data_o == '0));

    // R4: frame boundary restarts the running count
    p_restart_r4: assert property (@(posedge clk) disable iff (rst)
        edges.vs_rise |=> (run_cnt == '0));

    // R3: an edge outside the window leaves the count alone
    p_gate_r3: assert property (@(posedge clk) disable iff (rst)
        (edges.hs_rise && !win_ok_i && !edges.vs_rise) |=> $stable(run_cnt));
endmodule

// File: tb/sim_hsync_line_counter.sv
`timescale 1ns/1ps
module sim_hsync_line_counter;
    logic       clk = 1'b0;
    logic       rst;
    logic       hs, win, vs, re, sel;
    logic [7:0] rd;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // reference model state
    int  m_cnt, m_hold;
    bit  m_hs_p, m_vs_p;

    always #2.5 clk = ~clk;

    hsync_line_counter u0 (
        .clk(clk), .rst(rst), .hsync_i(hs), .win_ok_i(win), .vsync_i(vs),
        .rd_en_i(re), .rd_sel_i(sel), .rd_data_o(rd)
    );

    function automatic int sat_add(int v, int a);
        return (v + a > 1023) ? 1023 : v + a;
    endfunction

    function automatic logic [7:0] exp_rd(bit e, bit s, int h);
        return (e && s) ? 8'(h >> 2) : 8'd0;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(bit h, bit w, bit v, bit e, bit s);
        bit hr, vr, q;
        @(negedge clk);
        hs = h; win = w; vs = v; re = e; sel = s;
        hr = h && !m_hs_p;
        vr = v && !m_vs_p;
        q  = hr && w;
        if (vr) begin
            m_hold = sat_add(m_cnt, int'(q));
            m_cnt  = 0;
        end else if (q) begin
            m_cnt = sat_add(m_cnt, 1);
        end
        m_hs_p = h; m_vs_p = v;
        @(posedge clk);
    endtask

    task automatic rd_check(string req, logic [7:0] exp);
        @(negedge clk);
        re = 1'b1; sel = 1'b1;
        #1;
        chk(req, rd, exp);
    endtask

    task automatic pulses(int n, bit w, int len);
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < len; k++) step(1, w, vs, 0, 0);
            step(0, w, vs, 0, 0);
        end
    endtask

    task automatic frame_edge();
        step(0, 0, 1, 0, 0);
        step(0, 0, 0, 0, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got 0 expected 1 (run ended)");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        rst = 1'b1; hs = 0; win = 0; vs = 0; re = 0; sel = 0;
        m_cnt = 0; m_hold = 0; m_hs_p = 0; m_vs_p = 0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state
        rd_check("R1", 8'd0);

        // R2: long pulses counted once, 8 -> 2
        pulses(8, 1, 3);
        frame_edge();
        rd_check("R2", 8'd2);

        // R4: floor of 7/4 and restart
        pulses(7, 1, 1);
        frame_edge();
        rd_check("R4", 8'd1);

        // R3: window closed, nothing counted
        pulses(12, 0, 1);
        frame_edge();
        rd_check("R3", 8'd0);

        // R5: vsync edge with a qualified hsync edge
        pulses(3, 1, 1);
        step(1, 1, 1, 0, 0);
        step(0, 0, 0, 0, 0);
        rd_check("R5", 8'd1);
        pulses(3, 1, 1);
        frame_edge();
        rd_check("R5", 8'd0);

        // R9 and R6: vsync held high, pulses meanwhile belong to new frame
        pulses(8, 1, 1);
        step(0, 0, 1, 0, 0);
        rd_check("R9", 8'd2);
        pulses(8, 1, 2);
        rd_check("R6", 8'd2);
        step(0, 0, 0, 0, 0);
        pulses(4, 1, 1);
        rd_check("R6", 8'd2);
        frame_edge();
        rd_check("R9", 8'd3);

        // R8: read gating
        pulses(20, 1, 1);
        frame_edge();
        @(negedge clk); re = 1; sel = 0; #1; chk("R8", rd, 8'd0);
        @(negedge clk); re = 0; sel = 1; #1; chk("R8", rd, 8'd0);
        @(negedge clk); re = 1; sel = 1; #1; chk("R8", rd, 8'd5);

        // R7: saturation, then fresh frame
        pulses(1100, 1, 1);
        frame_edge();
        rd_check("R7", 8'd255);
        pulses(4, 1, 1);
        frame_edge();
        rd_check("R7", 8'd1);

        // random traffic against the model (R2 R3 R4 R6 R8)
        for (int i = 0; i < 6000; i++) begin
            bit h, w, v, e, s;
            h = 1'($urandom % 2);
            w = 1'(($urandom % 4) != 0);
            v = (i % 300 < 2) ? 1'b1 : 1'(($urandom % 97) == 0);
            e = 1'($urandom % 2);
            s = 1'($urandom % 2);
            step(h, w, v, e, s);
            #1;
            chk("R4/R8 random", rd, exp_rd(e, s, m_hold));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule